// File: doc/BRIEF.md
# Prescaled Periodic Timer with Interrupt Flags and Watchdog

This block is the free-running time base of a small microcontroller. A two-bit prescaler divides the bus clock by four. Its carry drives a fifteen-stage binary chain. Three functions share that one chain:
- an overflow event each time the low eight chain stages wrap;
- a periodic interrupt event taken from one of four high taps, chosen by a two-bit rate field;
- a watchdog that counts periodic events and asks for a system reset unless software restarts it in time.

Software reaches the block through a two-address register port. Address 0 is status/control; address 1 is a read-only snapshot of the low eight chain stages. In the status/control register, the two flag bits read back the flags. Writing a 1 to either of those bit positions acknowledges the matching flag. A single level interrupt request combines both flags with their enables. A separate strobe restarts the watchdog, and a one-cycle pulse reports a watchdog timeout.

Top module: `ptmr_timer`

## Requirements
- R1: After reset the chain counts every bus clock. Address 1 reads (cycles since reset / 4) mod 256, and is 0x00 at reset. A write to address 1 changes nothing.
- R2: The overflow flag (status bit 7) becomes 1 in the cycle after the 2^(PRE_BITS+8)th clock, counted from reset and repeating at that spacing. With the default, this is every 1024 cycles.
- R3: The periodic flag (status bit 6) becomes 1 at every multiple of 2^(PRE_BITS+CNT_BITS-3+rate) cycles since reset, where rate is status bits 1:0. The defaults give 16384, 32768, 65536 and 131072 for rates 0 to 3.
- R4: The status/control layout has two groups. The flags are bit 7 overflow and bit 6 periodic. The control fields are bit 5 overflow enable, bit 4 periodic enable, bits 1:0 rate, and bits 3:2 always read 0. Reset value is 0x03.
- R5: Writing address 0 with bit 7 or bit 6 set clears the matching flag. A 0 in that position leaves the flag unchanged. Those bits always read the flags, never the written data.
- R6: If a flag's set event and its acknowledge land on the same clock, the flag ends up 1.
- R7: `irq` is 1 exactly when (overflow flag and overflow enable) or (periodic flag and periodic enable).
- R8: The watchdog counts periodic events at the currently selected rate. On the WD_TICKS-th event (8 by default) after reset or after the last restart, `wd_reset_req` is 1 for exactly one cycle.
- R9: A `wd_clear` pulse restarts the watchdog count. It does not disturb the main chain or the address 1 value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status/control, 1 = chain snapshot |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| wd_clear | input | 1 | Watchdog restart strobe |
| irq | output | 1 | Interrupt request level |
| wd_reset_req | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The assertions are checked on every cycle and cover local cause-and-effect:
- each flag rises only after its tick, and the tick beats a same-cycle acknowledge;
- an acknowledge with no tick clears the flag;
- the snapshot only ever steps up by one;
- the rate only moves on a control write;
- a timeout pulse lasts one cycle and follows a selected tick that no restart accompanied.

Only the directed scenarios can show absolute timing: the 1024-cycle overflow spacing, each rate's period checked against its neighbours' tick instants, and the exact timeout cycle with and without a timely restart. They also cover the readback values.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned DATA_W = 8;

    // Bit positions that software decodes in the status/control register.
    localparam int unsigned BIT_OVF_FLAG = 7;
    localparam int unsigned BIT_RTI_FLAG = 6;
    localparam int unsigned BIT_OVF_IE   = 5;
    localparam int unsigned BIT_RTI_IE   = 4;

    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_CNT = 1'b1;

    typedef enum logic [1:0] {
        RATE_X1 = 2'b00,
        RATE_X2 = 2'b01,
        RATE_X4 = 2'b10,
        RATE_X8 = 2'b11
    } rti_rate_e;

    typedef struct packed {
        logic      ovf_flag;
        logic      rti_flag;
        logic      ovf_ie;
        logic      rti_ie;
        rti_rate_e rate;
    } ctl_s;
endpackage

// File: rtl/ptmr_divchain.sv
module ptmr_divchain #(
    parameter int unsigned PRE_BITS  = 2,
    parameter int unsigned CNT_BITS  = 15,
    parameter int unsigned OVF_STAGE = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [ptmr_pkg::DATA_W-1:0] cnt_byte,
    output logic                       ovf_tick,
    output logic [3:0]                 rti_tick
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned TOT_BITS = PRE_BITS + CNT_BITS;
    localparam int unsigned OVF_W    = PRE_BITS + OVF_STAGE;
    localparam int unsigned RTI_BASE = TOT_BITS - 3;

    // Prescaler occupies the low PRE_BITS, the chain the rest.
    logic [TOT_BITS-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q + TOT_BITS'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign cnt_byte = count_q[PRE_BITS +: ptmr_pkg::DATA_W];

    // A tick is the cycle before a wrap of the low stages.
    assign ovf_tick = &count_q[OVF_W-1:0];

    for (genvar r = 0; r < 4; r++) begin : g_rti
        assign rti_tick[r] = &count_q[RTI_BASE+r-1:0];
    end
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic                        addr,
    input  logic [ptmr_pkg::DATA_W-1:0] wdata,
    output logic [ptmr_pkg::DATA_W-1:0] rdata,
    input  logic [ptmr_pkg::DATA_W-1:0] cnt_byte,
    input  logic                        ovf_tick,
    input  logic [3:0]                  rti_tick,
    output logic                        rti_sel_tick,
    output logic                        irq,
    output logic                        ovf_flag,
    output logic                        rti_flag,
    output logic                        ovf_ie,
    output logic                        rti_ie,
    output logic [1:0]                  rate
);
    timeunit 1ns;
    timeprecision 1ps;
    import ptmr_pkg::*;

    ctl_s ctl_d, ctl_q;
    logic ctl_wr;
    logic unused_wbits;

    assign unused_wbits = ^wdata[3:2];
    assign rti_sel_tick = rti_tick[ctl_q.rate];

    always_comb begin
        ctl_d  = ctl_q;
        ctl_wr = wr && (addr == ADDR_CTL);
        if (ctl_wr) begin
            ctl_d.ovf_ie = wdata[BIT_OVF_IE];
            ctl_d.rti_ie = wdata[BIT_RTI_IE];
            ctl_d.rate   = rti_rate_e'(wdata[1:0]);
            if (wdata[BIT_OVF_FLAG]) ctl_d.ovf_flag = 1'b0;
            if (wdata[BIT_RTI_FLAG]) ctl_d.rti_flag = 1'b0;
        end
        // Set events take priority over a same-cycle acknowledge.
        if (ovf_tick)     ctl_d.ovf_flag = 1'b1;
        if (rti_sel_tick) ctl_d.rti_flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{ovf_flag: 1'b0, rti_flag: 1'b0, ovf_ie: 1'b0,
                               rti_ie: 1'b0, rate: RATE_X8};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        if (addr == ADDR_CTL)
            rdata = {ctl_q.ovf_flag, ctl_q.rti_flag, ctl_q.ovf_ie, ctl_q.rti_ie,
                     2'b00, ctl_q.rate};
        else
            rdata = cnt_byte;
    end

    assign irq      = (ctl_q.ovf_flag & ctl_q.ovf_ie) | (ctl_q.rti_flag & ctl_q.rti_ie);
    assign ovf_flag = ctl_q.ovf_flag;
    assign rti_flag = ctl_q.rti_flag;
    assign ovf_ie   = ctl_q.ovf_ie;
    assign rti_ie   = ctl_q.rti_ie;
    assign rate     = ctl_q.rate;
endmodule

// File: rtl/ptmr_watchdog.sv
module ptmr_watchdog #(
    parameter int unsigned WD_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    output logic bite
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned WD_BITS = (WD_TICKS > 2) ? $clog2(WD_TICKS) : 1;
    localparam logic [WD_BITS-1:0] LAST = WD_BITS'(WD_TICKS - 1);

    typedef struct packed {
        logic [WD_BITS-1:0] cnt;
        logic               bite;
    } wd_s;

    wd_s wd_d, wd_q;

    always_comb begin
        wd_d      = wd_q;
        wd_d.bite = 1'b0;
        if (clear) begin
            wd_d.cnt = '0;
        end else if (tick) begin
            if (wd_q.cnt == LAST) begin
                wd_d.cnt  = '0;
                wd_d.bite = 1'b1;
            end else begin
                wd_d.cnt = wd_q.cnt + WD_BITS'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign bite = wd_q.bite;
endmodule

// File: rtl/ptmr_timer.sv
module ptmr_timer #(
    parameter int unsigned PRE_BITS = 2,
    parameter int unsigned CNT_BITS = 15,
    parameter int unsigned WD_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       wd_clear,
    output logic       irq,
    output logic       wd_reset_req
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned OVF_STAGE = ptmr_pkg::DATA_W;

    logic [7:0] cnt_byte;
    logic       ovf_tick;
    logic [3:0] rti_tick;
    logic       rti_sel_tick;
    logic       ovf_flag, rti_flag, ovf_ie, rti_ie;
    logic [1:0] rate;

    ptmr_divchain #(
        .PRE_BITS (PRE_BITS),
        .CNT_BITS (CNT_BITS),
        .OVF_STAGE(OVF_STAGE)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_byte(cnt_byte),
        .ovf_tick(ovf_tick),
        .rti_tick(rti_tick)
    );

    ptmr_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .cnt_byte    (cnt_byte),
        .ovf_tick    (ovf_tick),
        .rti_tick    (rti_tick),
        .rti_sel_tick(rti_sel_tick),
        .irq         (irq),
        .ovf_flag    (ovf_flag),
        .rti_flag    (rti_flag),
        .ovf_ie      (ovf_ie),
        .rti_ie      (rti_ie),
        .rate        (rate)
    );

    ptmr_watchdog #(
        .WD_TICKS(WD_TICKS)
    ) u_wdog (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (rti_sel_tick),
        .clear(wd_clear),
        .bite (wd_reset_req)
    );
endmodule

// File: rtl/ptmr_timer_chk.sv
module ptmr_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic       wd_clear,
    input logic       irq,
    input logic       wd_reset_req,
    input logic [7:0] cnt_byte,
    input logic       ovf_tick,
    input logic       rti_sel_tick,
    input logic       ovf_flag,
    input logic       rti_flag,
    input logic       ovf_ie,
    input logic       rti_ie,
    input logic [1:0] rate
);
    timeunit 1ns;
    timeprecision 1ps;

    assert_cnt_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_byte != $past(cnt_byte)) |-> (cnt_byte == 8'($past(cnt_byte) + 8'd1)));

    assert_ovf_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(ovf_tick));

    assert_rti_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rti_flag) |-> $past(rti_sel_tick));

    assert_rate_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 1'b0) |=> $stable(rate));

    assert_ack_clears_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 1'b0 && reg_wdata[7] && !ovf_tick) |=> !ovf_flag);

    assert_ack_clears_rti_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 1'b0 && reg_wdata[6] && !rti_sel_tick) |=> !rti_flag);

    assert_set_beats_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_tick || rti_sel_tick) |=> (ovf_flag || rti_flag));

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_ie && !rti_ie) |-> !irq);

    assert_bite_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_req |=> !wd_reset_req);

    assert_bite_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_req |-> ($past(rti_sel_tick) && !$past(wd_clear)));
endmodule

bind ptmr_timer ptmr_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .wd_clear    (wd_clear),
    .irq         (irq),
    .wd_reset_req(wd_reset_req),
    .cnt_byte    (cnt_byte),
    .ovf_tick    (ovf_tick),
    .rti_sel_tick(rti_sel_tick),
    .ovf_flag    (ovf_flag),
    .rti_flag    (rti_flag),
    .ovf_ie      (ovf_ie),
    .rti_ie      (rti_ie),
    .rate        (rate)
);

// File: tb/ptmr_timer_tb.sv
module ptmr_timer_tb;
    timeunit 1ns;
    timeprecision 1ps;

    // Shorter chain keeps every period inside the run; periods follow R3's formula.
    localparam int PRE  = 2;
    localparam int CNT  = 12;
    localparam int WDT  = 8;
    localparam int OVF_P = 1 << (PRE + 8);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       wd_clear = 1'b0;
    logic       irq;
    logic       wd_reset_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    ptmr_timer #(.PRE_BITS(PRE), .CNT_BITS(CNT), .WD_TICKS(WDT)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wd_clear(wd_clear),
        .irq(irq), .wd_reset_req(wd_reset_req)
    );

    function automatic int rti_period(input int r);
        return 1 << (PRE + CNT - 3 + r);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=0x%0h expected=0x%0h", req, cyc, act, exp);
        end
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
        reg_wr    = 1'b0;
        reg_addr  = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        wd_clear = 1'b1;
        @(posedge clk);
        #1;
        wd_clear = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        wait_until(40);
        rd(1'b0, d); check("R4 reset status", d, 8'h03);
        rd(1'b1, d); check("R1 counter after 40 cycles", d, (40 >> 2) & 255);
        check("R7 irq after reset", irq, 0);
        check("R8 no timeout after reset", wd_reset_req, 0);
    endtask

    task automatic t_counter();
        logic [7:0] d;
        wait_until(1000);
        rd(1'b1, d); check("R1 counter at 1000", d, (1000 >> 2) & 255);
        wr(1'b1, 8'h55);
        rd(1'b1, d); check("R1 write to counter ignored", d, (cyc >> 2) & 255);
        rd(1'b0, d); check("R1 counter write leaves status", d, 8'h03);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        wait_until(OVF_P - 1);
        rd(1'b0, d); check("R2 no overflow before period", d[7], 0);
        wait_until(OVF_P);
        rd(1'b0, d); check("R2 overflow at 1024", d[7], 1);
        check("R7 irq masked with flag set", irq, 0);
        wr(1'b0, 8'h23);
        check("R7 irq with overflow enable", irq, 1);
        wr(1'b0, 8'hA3);
        rd(1'b0, d); check("R5 ack clears, bit reads flag", d, 8'h23);
        check("R7 irq drops after ack", irq, 0);
        wait_until(2 * OVF_P - 1);
        wr(1'b0, 8'hA3);
        rd(1'b0, d); check("R6 set wins over ack", d[7], 1);
        wr(1'b0, 8'h23);
        rd(1'b0, d); check("R5 writing 0 keeps flag", d[7], 1);
        wr(1'b0, 8'hA3);
        rd(1'b0, d); check("R5 ack clears again", d[7], 0);
        wait_until(3 * OVF_P - 1);
        rd(1'b0, d); check("R2 no overflow before third period", d[7], 0);
        wait_until(3 * OVF_P);
        rd(1'b0, d); check("R2 overflow spacing 1024", d[7], 1);
        wr(1'b0, 8'h83);
        rd(1'b0, d); check("R4 status after ack and disable", d, 8'h03);
    endtask

    task automatic t_rates();
        logic [7:0] d;
        // Rate 3 from reset: quiet at rate 2's instant, set at its own.
        wait_until(rti_period(2));
        rd(1'b0, d); check("R3 rate 3 quiet at rate 2 tick", d[6], 0);
        wait_until(rti_period(3) - 1);
        rd(1'b0, d); check("R3 rate 3 quiet before period", d[6], 0);
        wait_until(rti_period(3));
        rd(1'b0, d); check("R3 rate 3 period", d[6], 1);
        wr(1'b0, 8'hC2);
        rd(1'b0, d); check("R5 rti ack clears", d[6], 0);
        // Rate 2: next tick at 3 * period(2).
        wait_until(5 * rti_period(1));
        rd(1'b0, d); check("R3 rate 2 quiet at rate 1 tick", d[6], 0);
        wait_until(3 * rti_period(2) - 1);
        rd(1'b0, d); check("R3 rate 2 quiet before tick", d[6], 0);
        wait_until(3 * rti_period(2));
        rd(1'b0, d); check("R3 rate 2 period", d[6], 1);
        wr(1'b0, 8'h41);
        // Rate 1: next tick at 7 * period(1).
        wait_until(13 * rti_period(0));
        rd(1'b0, d); check("R3 rate 1 quiet at rate 0 tick", d[6], 0);
        wait_until(7 * rti_period(1) - 1);
        rd(1'b0, d); check("R3 rate 1 quiet before tick", d[6], 0);
        wait_until(7 * rti_period(1));
        rd(1'b0, d); check("R3 rate 1 period", d[6], 1);
        wr(1'b0, 8'h40);
        // Rate 0: next tick at 15 * period(0).
        wait_until(15 * rti_period(0) - 1);
        rd(1'b0, d); check("R3 rate 0 quiet before tick", d[6], 0);
        wait_until(15 * rti_period(0));
        rd(1'b0, d); check("R3 rate 0 period", d[6], 1);
    endtask

    task automatic t_irq_rti();
        logic [7:0] d;
        check("R7 irq masked, both flags set", irq, 0);
        wr(1'b0, 8'h10);
        check("R7 irq from periodic flag", irq, 1);
        rd(1'b0, d); check("R4 status layout", d, 8'hD0);
        wr(1'b0, 8'hD0);
        rd(1'b0, d); check("R5 acks read back as flags", d, 8'h10);
        check("R7 irq after both acks", irq, 0);
    endtask

    task automatic t_watchdog();
        logic [7:0] d;
        int t_clr;
        int t_bite;
        wait_until(31000);
        pulse_clear();
        // Ticks at rate 0 land on multiples of period(0); 8th after the clear would bite.
        wait_until(45000);
        pulse_clear();
        t_clr = cyc;
        rd(1'b1, d); check("R9 clear leaves main counter", d, (t_clr >> 2) & 255);
        wait_until(16 * rti_period(0) + 7 * rti_period(0));
        check("R9 timely clear prevents timeout", wd_reset_req, 0);
        t_bite = ((t_clr / rti_period(0)) + WDT) * rti_period(0);
        wait_until(t_bite - 1);
        check("R8 no timeout before eighth tick", wd_reset_req, 0);
        wait_until(t_bite);
        check("R8 timeout on eighth tick", wd_reset_req, 1);
        wait_until(t_bite + 1);
        check("R8 timeout lasts one cycle", wd_reset_req, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_counter();
        t_overflow();
        t_rates();
        t_irq_rti();
        t_watchdog();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule